// File: doc/BRIEF.md
# Single-Line Cache Coherence Controller with Transient States

This block is the cache-side controller for one cache line in a directory-based protocol with three stable states: invalid, shared and modified. A processor asks for a read or a write. The controller either answers at once from the line, or sends a shared or exclusive request to the directory and waits for the reply. Transactions are not atomic. For that reason the controller has split transient states, which wait for a data reply. It also has a race state for an invalidation that arrives while an upgrade from shared to modified is still outstanding.

The processor holds its request until `grant` pulses. Incoming messages come as a single-cycle `in_valid` strobe with a type and a data word. Outgoing messages are a type code and a data word that are valid in the same cycle as the event that causes them. A design-time parameter chooses how an overlapping invalidation is handled. In race mode the controller acknowledges it at once and enters a race state. In defer mode it holds the invalidation until the exclusive reply arrives. In both modes the pending write is performed exactly once and the dirty data is written back, so writes to the line stay serialized and reach the other caches.

States and their 3-bit codes: I=0, S=1, M=2, IS_D=3 (read miss waiting for shared data), IM_A=4 (write miss waiting for exclusive reply), SM_A=5 (upgrade waiting for exclusive reply), SM_A_I=6 (race: upgrade outstanding, invalidation already acknowledged), SM_A_HELD=7 (upgrade outstanding, invalidation deferred).

Top module: `coh_line_ctrl`

## Requirements
- R1: During and straight after reset the state is I (0), `grant` is 0, `out_type` is 0 (none), and `out_data` and `rd_data` are 0.
- R2: In I, a read request sends type 1 (shared request) and moves to IS_D (3). A write request sends type 2 (exclusive request), captures `req_wdata` and moves to IM_A (4). Neither gives a grant.
- R3: In IS_D, an incoming type 1 (shared data) grants the read with `rd_data` equal to `in_data`, stores that word and moves to S (1). In IM_A, an incoming type 2 (exclusive reply) grants the write, makes the line hold the captured write data and moves to M (2).
- R4: A read in S or M is granted in the same cycle, with `rd_data` equal to the stored word. A write in M is granted in the same cycle and replaces the stored word.
- R5: A write in S sends type 2 and moves to SM_A (5) with no grant. A type 2 reply in SM_A grants the write, stores the captured data and moves to M.
- R6: In any transient state (3 to 7), a processor request gives no grant and sends no message.
- R7: An incoming invalidation (type 3) in S sends an acknowledgement (type 3) and moves to I. In M it sends a writeback (type 4) carrying the stored word and moves to I. In I, IS_D or IM_A it sends an acknowledgement and leaves the state unchanged.
- R8: With `DEFER_INV`=0, an invalidation in SM_A sends an acknowledgement and moves to SM_A_I (6). A type 2 reply in SM_A_I grants the write once, sends a writeback carrying the captured write data and moves to I.
- R9: With `DEFER_INV`=1, an invalidation in SM_A sends nothing and moves to SM_A_HELD (7). A type 2 reply there grants the write once, sends a writeback carrying the captured write data and moves to I.
- R10: When `in_valid` is high with a nonzero type in the same cycle as a processor request in I, S or M, the message is handled and the request is neither granted nor started in that cycle.
- R11: A message with no meaning in the current state has no effect. This covers type 0, data replies outside their matching wait state, and an invalidation in SM_A_I or SM_A_HELD. No message is sent, no grant is given, and the state and stored word are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request, held until granted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| grant | output | 1 | Request completes this cycle |
| rd_data | output | DW | Read data on a read grant, else 0 |
| in_valid | input | 1 | Incoming message strobe |
| in_type | input | 2 | 0 none, 1 shared data, 2 exclusive reply, 3 invalidation |
| in_data | input | DW | Incoming data word |
| out_type | output | 3 | 0 none, 1 shared request, 2 exclusive request, 3 invalidation ack, 4 writeback |
| out_data | output | DW | Writeback data, else 0 |
| state_o | output | 3 | Current line state code |

## Verification
The bench builds two copies with `DW`=16: one with `DEFER_INV`=0 and one with `DEFER_INV`=1. Both receive the same stimulus. A single random stream therefore drives the race state and the held-invalidation state, and the two resolutions of an overlapping invalidation can be compared cycle by cycle. Random messages of every type arrive in every state. This covers collisions between processor requests and messages, as well as stray replies. Directed sequences force the shared-to-modified upgrade with an invalidation in between.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [2:0] {
        ST_I         = 3'd0,
        ST_S         = 3'd1,
        ST_M         = 3'd2,
        ST_IS_D      = 3'd3,
        ST_IM_A      = 3'd4,
        ST_SM_A      = 3'd5,
        ST_SM_A_I    = 3'd6,
        ST_SM_A_HELD = 3'd7
    } line_st_e;

    typedef enum logic [2:0] {
        OM_NONE    = 3'd0,
        OM_GET_SH  = 3'd1,
        OM_GET_EX  = 3'd2,
        OM_INV_ACK = 3'd3,
        OM_WB      = 3'd4
    } out_msg_e;

    typedef enum logic [1:0] {
        IM_NONE    = 2'd0,
        IM_SH_DATA = 2'd1,
        IM_EX_DATA = 2'd2,
        IM_INV     = 2'd3
    } in_msg_e;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_pend,
    input  logic          wr_req,
    input  logic          wr_in,
    input  logic          wr_pend,
    input  logic          rd_en,
    input  logic          rd_fwd,
    input  logic          wb_en,
    input  logic          wb_pend,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] in_data,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] out_data
);

    logic [DW-1:0] line_q;
    logic [DW-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            pend_q <= '0;
        end else begin
            if (cap_pend)
                pend_q <= req_wdata;
            if (wr_in)
                line_q <= in_data;
            else if (wr_pend)
                line_q <= pend_q;
            else if (wr_req)
                line_q <= req_wdata;
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_en)
            rd_data = rd_fwd ? in_data : line_q;
        out_data = '0;
        if (wb_en)
            out_data = wb_pend ? pend_q : line_q;
    end

endmodule

// File: rtl/coh_fsm.sv
module coh_fsm
    import coh_pkg::*;
#(
    parameter bit DEFER_INV = 1'b0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  logic     req_write,
    input  logic     in_valid,
    input  in_msg_e  in_type,
    output line_st_e st_q,
    output out_msg_e omsg,
    output logic     grant,
    output logic     cap_pend,
    output logic     wr_req,
    output logic     wr_in,
    output logic     wr_pend,
    output logic     rd_en,
    output logic     rd_fwd,
    output logic     wb_en,
    output logic     wb_pend
);

    line_st_e st_d;
    logic     msg_act;

    assign msg_act = in_valid && (in_type != IM_NONE);

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= ST_I;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d     = st_q;
        omsg     = OM_NONE;
        grant    = 1'b0;
        cap_pend = 1'b0;
        wr_req   = 1'b0;
        wr_in    = 1'b0;
        wr_pend  = 1'b0;
        rd_en    = 1'b0;
        rd_fwd   = 1'b0;
        wb_en    = 1'b0;
        wb_pend  = 1'b0;
        unique case (st_q)
            ST_I: begin
                if (msg_act) begin
                    if (in_type == IM_INV)
                        omsg = OM_INV_ACK;
                end else if (req_valid) begin
                    if (req_write) begin
                        omsg     = OM_GET_EX;
                        cap_pend = 1'b1;
                        st_d     = ST_IM_A;
                    end else begin
                        omsg = OM_GET_SH;
                        st_d = ST_IS_D;
                    end
                end
            end
            ST_IS_D: begin
                if (msg_act && in_type == IM_SH_DATA) begin
                    grant  = 1'b1;
                    rd_en  = 1'b1;
                    rd_fwd = 1'b1;
                    wr_in  = 1'b1;
                    st_d   = ST_S;
                end else if (msg_act && in_type == IM_INV) begin
                    omsg = OM_INV_ACK;
                end
            end
            ST_IM_A: begin
                if (msg_act && in_type == IM_EX_DATA) begin
                    grant   = 1'b1;
                    wr_pend = 1'b1;
                    st_d    = ST_M;
                end else if (msg_act && in_type == IM_INV) begin
                    omsg = OM_INV_ACK;
                end
            end
            ST_S: begin
                if (msg_act) begin
                    if (in_type == IM_INV) begin
                        omsg = OM_INV_ACK;
                        st_d = ST_I;
                    end
                end else if (req_valid) begin
                    if (req_write) begin
                        omsg     = OM_GET_EX;
                        cap_pend = 1'b1;
                        st_d     = ST_SM_A;
                    end else begin
                        grant = 1'b1;
                        rd_en = 1'b1;
                    end
                end
            end
            ST_M: begin
                if (msg_act) begin
                    if (in_type == IM_INV) begin
                        omsg  = OM_WB;
                        wb_en = 1'b1;
                        st_d  = ST_I;
                    end
                end else if (req_valid) begin
                    grant = 1'b1;
                    if (req_write)
                        wr_req = 1'b1;
                    else
                        rd_en = 1'b1;
                end
            end
            ST_SM_A: begin
                if (msg_act && in_type == IM_EX_DATA) begin
                    grant   = 1'b1;
                    wr_pend = 1'b1;
                    st_d    = ST_M;
                end else if (msg_act && in_type == IM_INV) begin
                    if (DEFER_INV) begin
                        st_d = ST_SM_A_HELD;
                    end else begin
                        omsg = OM_INV_ACK;
                        st_d = ST_SM_A_I;
                    end
                end
            end
            ST_SM_A_I, ST_SM_A_HELD: begin
                if (msg_act && in_type == IM_EX_DATA) begin
                    grant   = 1'b1;
                    wr_pend = 1'b1;
                    omsg    = OM_WB;
                    wb_en   = 1'b1;
                    wb_pend = 1'b1;
                    st_d    = ST_I;
                end
            end
            default: st_d = ST_I;
        endcase
    end

    // R6
    transient_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q inside {ST_IS_D, ST_IM_A, ST_SM_A, ST_SM_A_I, ST_SM_A_HELD} && !in_valid)
            |-> (!grant && omsg == OM_NONE));

    // R3
    shared_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IS_D && in_valid && in_type == IM_SH_DATA) |=> (st_q == ST_S));

    // R7
    dirty_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_M && in_valid && in_type == IM_INV) |=> (st_q == ST_I));

    // R10
    msg_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_type != IM_NONE) |-> !(omsg inside {OM_GET_SH, OM_GET_EX}));

    generate
        if (DEFER_INV) begin : g_defer_chk
            // R9
            held_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q == ST_SM_A && in_valid && in_type == IM_INV)
                    |=> (st_q == ST_SM_A_HELD && $past(omsg) == OM_NONE));
        end else begin : g_race_chk
            // R8
            race_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q == ST_SM_A_I && in_valid && in_type == IM_EX_DATA)
                    |-> (grant && omsg == OM_WB));
        end
    endgenerate

endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
    import coh_pkg::*;
#(
    parameter int DW        = 16,
    parameter bit DEFER_INV = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [DW-1:0] req_wdata,
    output logic          grant,
    output logic [DW-1:0] rd_data,
    input  logic          in_valid,
    input  logic [1:0]    in_type,
    input  logic [DW-1:0] in_data,
    output logic [2:0]    out_type,
    output logic [DW-1:0] out_data,
    output logic [2:0]    state_o
);

    line_st_e st_q;
    out_msg_e omsg;
    logic     cap_pend, wr_req, wr_in, wr_pend, rd_en, rd_fwd, wb_en, wb_pend;

    coh_fsm #(.DEFER_INV(DEFER_INV)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .in_valid  (in_valid),
        .in_type   (in_msg_e'(in_type)),
        .st_q      (st_q),
        .omsg      (omsg),
        .grant     (grant),
        .cap_pend  (cap_pend),
        .wr_req    (wr_req),
        .wr_in     (wr_in),
        .wr_pend   (wr_pend),
        .rd_en     (rd_en),
        .rd_fwd    (rd_fwd),
        .wb_en     (wb_en),
        .wb_pend   (wb_pend)
    );

    coh_line_store #(.DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_pend  (cap_pend),
        .wr_req    (wr_req),
        .wr_in     (wr_in),
        .wr_pend   (wr_pend),
        .rd_en     (rd_en),
        .rd_fwd    (rd_fwd),
        .wb_en     (wb_en),
        .wb_pend   (wb_pend),
        .req_wdata (req_wdata),
        .in_data   (in_data),
        .rd_data   (rd_data),
        .out_data  (out_data)
    );

    assign out_type = omsg;
    assign state_o  = st_q;

endmodule

// File: tb/coh_line_ctrl_bench.sv
module coh_line_ctrl_bench;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_type = 2'd0;
    logic [DW-1:0] in_data = '0;

    logic          g0, g1;
    logic [DW-1:0] rd0, rd1, od0, od1;
    logic [2:0]    ot0, ot1, st0, st1;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [2:0]    m_st [2];
    logic [DW-1:0] m_dq [2];
    logic [DW-1:0] m_pq [2];

    always #4 clk = ~clk;

    coh_line_ctrl #(.DW(DW), .DEFER_INV(1'b0)) u_coh_line_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wdata(req_wdata), .grant(g0), .rd_data(rd0), .in_valid(in_valid),
        .in_type(in_type), .in_data(in_data), .out_type(ot0), .out_data(od0),
        .state_o(st0));

    coh_line_ctrl #(.DW(DW), .DEFER_INV(1'b1)) u_coh_line_ctrl_defer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wdata(req_wdata), .grant(g1), .rd_data(rd1), .in_valid(in_valid),
        .in_type(in_type), .in_data(in_data), .out_type(ot1), .out_data(od1),
        .state_o(st1));

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Expected behaviour computed from the requirements.
    task automatic model(input bit defer, input logic [2:0] st, input logic [DW-1:0] dq,
                         input logic [DW-1:0] pq,
                         output logic [2:0] nst, output logic [DW-1:0] ndq,
                         output logic [DW-1:0] npq, output logic g, output logic [DW-1:0] rd,
                         output logic [2:0] ot, output logic [DW-1:0] od, output string tag);
        bit act;
        act = in_valid && in_type != 2'd0;
        nst = st; ndq = dq; npq = pq; g = 0; rd = '0; ot = 0; od = '0; tag = "R11";
        case (st)
            3'd0: if (act) begin
                if (in_type == 2'd3) begin ot = 3; tag = "R7"; end
                else if (req_valid) tag = "R10";
            end else if (req_valid) begin
                tag = "R2";
                if (req_write) begin ot = 2; npq = req_wdata; nst = 3'd4; end
                else begin ot = 1; nst = 3'd3; end
            end
            3'd3: if (act && in_type == 2'd1) begin
                g = 1; rd = in_data; ndq = in_data; nst = 3'd1; tag = "R3";
            end else if (act && in_type == 2'd3) begin ot = 3; tag = "R7"; end
            else if (req_valid) tag = "R6";
            3'd4: if (act && in_type == 2'd2) begin
                g = 1; ndq = pq; nst = 3'd2; tag = "R3";
            end else if (act && in_type == 2'd3) begin ot = 3; tag = "R7"; end
            else if (req_valid) tag = "R6";
            3'd1: if (act) begin
                if (in_type == 2'd3) begin ot = 3; nst = 3'd0; tag = "R7"; end
                else if (req_valid) tag = "R10";
            end else if (req_valid) begin
                if (req_write) begin ot = 2; npq = req_wdata; nst = 3'd5; tag = "R5"; end
                else begin g = 1; rd = dq; tag = "R4"; end
            end
            3'd2: if (act) begin
                if (in_type == 2'd3) begin ot = 4; od = dq; nst = 3'd0; tag = "R7"; end
                else if (req_valid) tag = "R10";
            end else if (req_valid) begin
                g = 1; tag = "R4";
                if (req_write) ndq = req_wdata; else rd = dq;
            end
            3'd5: if (act && in_type == 2'd2) begin
                g = 1; ndq = pq; nst = 3'd2; tag = "R5";
            end else if (act && in_type == 2'd3) begin
                if (defer) begin nst = 3'd7; tag = "R9"; end
                else begin ot = 3; nst = 3'd6; tag = "R8"; end
            end else if (req_valid) tag = "R6";
            default: if (act && in_type == 2'd2) begin
                g = 1; ndq = pq; ot = 4; od = pq; nst = 3'd0;
                tag = defer ? "R9" : "R8";
            end else if (req_valid) tag = "R6";
        endcase
    endtask

    // One cycle: drive at the falling edge, check before the rising edge.
    task automatic cyc(input bit rv, input bit rw, input logic [DW-1:0] wd,
                       input bit iv, input logic [1:0] it, input logic [DW-1:0] id);
        logic [2:0] nst, ot;
        logic [DW-1:0] ndq, npq, rd, od;
        logic g;
        string tag;
        @(negedge clk);
        req_valid = rv; req_write = rw; req_wdata = wd;
        in_valid = iv; in_type = it; in_data = id;
        #3;
        for (int k = 0; k < 2; k++) begin
            model(k[0], m_st[k], m_dq[k], m_pq[k], nst, ndq, npq, g, rd, ot, od, tag);
            chk(tag, k == 0 ? "race state" : "defer state", int'(k == 0 ? st0 : st1), int'(m_st[k]));
            chk(tag, "grant",    int'(k == 0 ? g0 : g1),   int'(g));
            chk(tag, "rd_data",  int'(k == 0 ? rd0 : rd1), int'(rd));
            chk(tag, "out_type", int'(k == 0 ? ot0 : ot1), int'(ot));
            chk(tag, "out_data", int'(k == 0 ? od0 : od1), int'(od));
            m_st[k] = nst; m_dq[k] = ndq; m_pq[k] = npq;
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < 2; k++) begin m_st[k] = 0; m_dq[k] = '0; m_pq[k] = '0; end
        repeat (3) @(negedge clk);
        #3;
        // R1 reset state
        chk("R1", "state",    int'(st0), 0);
        chk("R1", "state",    int'(st1), 0);
        chk("R1", "grant",    int'(g0 | g1), 0);
        chk("R1", "out_type", int'(ot0 | ot1), 0);
        chk("R1", "data",     int'(rd0 | od0 | rd1 | od1), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2/R3: read miss, fill, then R4 hit
        cyc(1, 0, 16'h0, 0, 0, 0);
        cyc(1, 0, 16'h0, 0, 0, 0);
        cyc(1, 0, 16'h0, 1, 1, 16'hA5A5);
        cyc(1, 0, 16'h0, 0, 0, 0);
        // R5 upgrade, overlapping invalidation, R8/R9 resolution
        cyc(1, 1, 16'h1234, 0, 0, 0);
        cyc(1, 1, 16'h9999, 0, 0, 0);
        cyc(1, 1, 16'h9999, 1, 3, 0);
        cyc(1, 1, 16'h9999, 1, 3, 0);          // R11 second invalidation
        cyc(1, 1, 16'h9999, 1, 2, 16'hFFFF);
        cyc(0, 0, 16'h0, 0, 0, 0);
        // R3 write miss, R10 collision in M, R7 dirty writeback
        cyc(1, 1, 16'h00C3, 0, 0, 0);
        cyc(1, 1, 16'h00C3, 1, 2, 16'h1111);
        cyc(1, 1, 16'h5A5A, 1, 3, 0);
        cyc(1, 0, 16'h0, 1, 1, 16'h7777);      // R11 stray shared data in I
        // R5 upgrade completes without invalidation
        cyc(1, 0, 16'h0, 0, 0, 0);
        cyc(1, 0, 16'h0, 1, 1, 16'h4242);
        cyc(1, 1, 16'hBEEF, 0, 0, 0);
        cyc(1, 1, 16'hBEEF, 1, 2, 0);
        cyc(1, 0, 16'h0, 0, 0, 0);

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            bit iv;
            iv = ($urandom % 100) < 35;
            cyc(($urandom % 100) < 60, $urandom % 2, DW'($urandom),
                iv, iv ? 2'($urandom % 4) : 2'd0, DW'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule